// File: doc/BRIEF.md
# Queued Flash Command Controller

This controller sits between a host write/read bus and a small register model of a flash array. The array is split into equal erase blocks. Every change to the array comes from a two-write command sequence. A program writes a setup code and then the data. An erase writes a setup code and then a confirm code at an address inside the target block. An accepted operation goes into a one-entry queue. From the queue it is handed to one of two execution engines, one for erase and one for program. A program can therefore run in one block while a different block is being erased.

Each block has a lock bit. When the write-protect input is low, any operation aimed at a locked block is refused. A global status byte shows the queue, engine and overflow state. A three-bit status field per block shows busy, refused-by-lock and locked. A ready output is low whenever anything is queued or executing. The bus is selected only when both active-low chip enables are low. A mode input chooses 8-bit or 16-bit access.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: When either `ce0_ni` or `ce1_ni` is high, writes have no effect on the command state, the queue or the array, and `rdata_o` reads 0.
- R2: Command codes are taken from `wdata_i[7:0]`. Program is 0x40 followed by a data write. Erase is 0x20 followed by 0xD0 at any address in the target block. Any other second write abandons the sequence. A lone 0xD0 or an unknown code does nothing.
- R3: A program sets each target byte to old AND new data, so it can only clear bits. In 8-bit mode (`word_mode_i`=0) the full address picks the byte, and a read returns that byte in bits 7:0 with 0 in bits 15:8.
- R4: After an erase, every byte of the target block reads 0xFF and all other blocks keep their contents.
- R5: A single program or erase on an idle controller holds `ready_o` low for exactly N+1 cycles after the confirm write, where N is PROG_CYCLES or ERASE_CYCLES.
- R6: An operation confirmed while its engine is busy waits in the one-entry queue, with `gsr_o[0]`=1, and executes later.
- R7: An operation confirmed while the queue holds an entry is dropped and sets the sticky overflow bit `gsr_o[4]`. The 0x50 command clears it.
- R8: A queued program may run while an erase runs in a different block. In that case `gsr_o[2]` (erase active) and `gsr_o[3]` (program active) are both 1, and the erasing block's busy bit is 1.
- R9: A program aimed at the block being erased stays queued until the erase completes, and is then applied to the erased data.
- R10: 0x60 followed by 0x01 sets the addressed block's lock bit (`bsr_o[3b]`). While `wp_ni` is low, a program or erase on a locked block is refused, leaves the array unchanged and sets `bsr_o[3b+1]`. 0x50 clears that error bit. While `wp_ni` is high, locked blocks can be modified.
- R11: In 16-bit mode (`word_mode_i`=1), address bit 0 is ignored. A read returns the odd byte in bits 15:8 and the even byte in bits 7:0, and a program applies both halves of `wdata_i`.
- R12: After reset, `ready_o`=1, `gsr_o`=0, `bsr_o`=0 and every array byte reads 0xFF. `ready_o` is 1 exactly when nothing is queued and no engine is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce0_ni | input | 1 | Chip enable 0, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| word_mode_i | input | 1 | 0 = 8-bit bus, 1 = 16-bit bus |
| addr_i | input | ADDR_W | Byte address (6 bits by default) |
| wdata_i | input | 16 | Write data or command code in bits 7:0 |
| wp_ni | input | 1 | Write protect, active low |
| rdata_o | output | 16 | Array read data |
| ready_o | output | 1 | 1 = idle, 0 = operation queued or running |
| gsr_o | output | 8 | Global status: queue full, busy, erase active, program active, overflow |
| bsr_o | output | 3*NUM_BLOCKS | Per-block status: {busy, lock error, locked} |

## Verification
The assertions assume that the host issues at most one bus write per cycle and that chip enables and address are stable while the strobe is high. The engine assertions assume that reset is applied before any command. The stimulus drives every input on the falling clock edge and holds each write for one full cycle. It changes `wp_ni` and `word_mode_i` only while the controller is idle. Because of this, no protection or width change can arrive in the middle of a command sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_kind_e;

  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] CMD_LOCK_OK = 8'h01;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic              req_valid_o,
  output op_kind_e          req_kind_o,
  output logic              lock_set_o,
  output logic              clr_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_ERASE, ST_LOCK} dec_st_e;

  dec_st_e st_q, st_d;
  logic    wr_en;

  assign wr_en = sel_i && wr_i;

  always_comb begin
    st_d        = st_q;
    req_valid_o = 1'b0;
    req_kind_o  = OP_NONE;
    lock_set_o  = 1'b0;
    clr_o       = 1'b0;
    if (wr_en) begin
      unique case (st_q)
        ST_IDLE: begin
          unique case (wdata_i[7:0])
            CMD_PROG:  st_d = ST_PROG;
            CMD_ERASE: st_d = ST_ERASE;
            CMD_LOCK:  st_d = ST_LOCK;
            CMD_CLEAR: clr_o = 1'b1;
            default:   st_d = ST_IDLE;
          endcase
        end
        ST_PROG: begin
          st_d        = ST_IDLE;
          req_valid_o = 1'b1;
          req_kind_o  = OP_PROG;
        end
        ST_ERASE: begin
          st_d = ST_IDLE;
          if (wdata_i[7:0] == CMD_CONFIRM) begin
            req_valid_o = 1'b1;
            req_kind_o  = OP_ERASE;
          end
        end
        default: begin
          st_d = ST_IDLE;
          lock_set_o = (wdata_i[7:0] == CMD_LOCK_OK);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  // R1
  desel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |=> $stable(st_q));

  logic unused_addr;
  assign unused_addr = ^addr_i;
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic act_o,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;

  assign done_o = act_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      act_o <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_o <= 1'b1;
      cnt_q <= CW'(CYCLES - 1);
    end else if (act_o) begin
      if (cnt_q == '0) act_o <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && cnt_q != '0) |=> (act_o && cnt_q == $past(cnt_q) - 1'b1));

  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_o);
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int unsigned NUM_BLOCKS  = 16,
  parameter int unsigned BLOCK_BYTES = 4,
  localparam int unsigned DEPTH  = NUM_BLOCKS * BLOCK_BYTES,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned BLK_W  = $clog2(NUM_BLOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic [BLK_W-1:0]  erase_blk_i,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [15:0]       prog_data_i,
  input  logic              prog_wide_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_wide_i,
  output logic [15:0]       rd_data_o
);
  logic [DEPTH-1:0][7:0] mem;
  logic [ADDR_W-1:0]     prog_hi;

  assign prog_hi = {prog_addr_i[ADDR_W-1:1], 1'b1};

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [BLK_W-1:0]  MY_BLK  = BLK_W'(g / BLOCK_BYTES);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    logic [7:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                      cell_q <= 8'hFF;
      else if (erase_i && erase_blk_i == MY_BLK)        cell_q <= 8'hFF;
      else if (prog_i && prog_addr_i == MY_ADDR)        cell_q <= cell_q & prog_data_i[7:0];
      else if (prog_i && prog_wide_i && prog_hi == MY_ADDR)
                                                        cell_q <= cell_q & prog_data_i[15:8];
    assign mem[g] = cell_q;
  end

  always_comb begin
    if (rd_wide_i)
      rd_data_o = {mem[{rd_addr_i[ADDR_W-1:1], 1'b1}], mem[{rd_addr_i[ADDR_W-1:1], 1'b0}]};
    else
      rd_data_o = {8'h00, mem[rd_addr_i]};
  end

  // R9
  erase_prog_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i && prog_i) |-> (erase_blk_i != prog_addr_i[ADDR_W-1 -: BLK_W]));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS   = 16,
  parameter int unsigned BLOCK_BYTES  = 4,
  parameter int unsigned PROG_CYCLES  = 3,
  parameter int unsigned ERASE_CYCLES = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_BLOCKS * BLOCK_BYTES),
  localparam int unsigned OFF_W  = $clog2(BLOCK_BYTES),
  localparam int unsigned BLK_W  = $clog2(NUM_BLOCKS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce0_ni,
  input  logic                    ce1_ni,
  input  logic                    wr_i,
  input  logic                    word_mode_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [15:0]             wdata_i,
  input  logic                    wp_ni,
  output logic [15:0]             rdata_o,
  output logic                    ready_o,
  output logic [7:0]              gsr_o,
  output logic [3*NUM_BLOCKS-1:0] bsr_o
);
  logic     sel, req_valid, lock_set, clr;
  op_kind_e req_kind;
  logic [BLK_W-1:0] req_blk;

  assign sel     = !ce0_ni && !ce1_ni;
  assign req_blk = addr_i[ADDR_W-1:OFF_W];

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .sel_i(sel), .wr_i, .addr_i, .wdata_i,
    .req_valid_o(req_valid), .req_kind_o(req_kind),
    .lock_set_o(lock_set), .clr_o(clr)
  );

  // one-entry queue
  logic              q_valid, q_wide;
  op_kind_e          q_kind;
  logic [ADDR_W-1:0] q_addr;
  logic [15:0]       q_data;
  logic [BLK_W-1:0]  q_blk;
  logic [NUM_BLOCKS-1:0] locked, lock_err;
  logic              ovf, refuse, accept;

  assign refuse = req_valid && !q_valid && locked[req_blk] && !wp_ni;
  assign accept = req_valid && !q_valid && !refuse;
  assign q_blk  = q_addr[ADDR_W-1:OFF_W];

  // engines
  logic              e_act, e_done, e_start, p_act, p_done, p_start, p_wide;
  logic [BLK_W-1:0]  e_blk, p_blk;
  logic [ADDR_W-1:0] p_addr;
  logic [15:0]       p_data;

  assign p_blk   = p_addr[ADDR_W-1:OFF_W];
  assign e_start = q_valid && q_kind == OP_ERASE && !e_act && !(p_act && p_blk == q_blk);
  assign p_start = q_valid && q_kind == OP_PROG  && !p_act && !(e_act && e_blk == q_blk);

  flash_op_timer #(.CYCLES(ERASE_CYCLES)) u_erase_tmr (
    .clk_i, .rst_ni, .start_i(e_start), .act_o(e_act), .done_o(e_done));
  flash_op_timer #(.CYCLES(PROG_CYCLES)) u_prog_tmr (
    .clk_i, .rst_ni, .start_i(p_start), .act_o(p_act), .done_o(p_done));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      q_valid <= 1'b0;
      q_kind  <= OP_NONE;
      q_addr  <= '0;
      q_data  <= '0;
      q_wide  <= 1'b0;
    end else if (accept) begin
      q_valid <= 1'b1;
      q_kind  <= req_kind;
      q_addr  <= word_mode_i ? {addr_i[ADDR_W-1:1], 1'b0} : addr_i;
      q_data  <= word_mode_i ? wdata_i : {8'h00, wdata_i[7:0]};
      q_wide  <= word_mode_i;
    end else if (e_start || p_start) begin
      q_valid <= 1'b0;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      e_blk  <= '0;
      p_addr <= '0;
      p_data <= '0;
      p_wide <= 1'b0;
    end else begin
      if (e_start) e_blk <= q_blk;
      if (p_start) begin
        p_addr <= q_addr;
        p_data <= q_data;
        p_wide <= q_wide;
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      locked   <= '0;
      lock_err <= '0;
      ovf      <= 1'b0;
    end else begin
      if (lock_set) locked[req_blk] <= 1'b1;
      if (clr) begin
        lock_err <= '0;
        ovf      <= 1'b0;
      end else begin
        if (refuse) lock_err[req_blk] <= 1'b1;
        if (req_valid && q_valid) ovf <= 1'b1;
      end
    end

  logic [15:0] arr_rd;

  flash_array_model #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_array (
    .clk_i, .rst_ni,
    .erase_i(e_done), .erase_blk_i(e_blk),
    .prog_i(p_done), .prog_addr_i(p_addr), .prog_data_i(p_data), .prog_wide_i(p_wide),
    .rd_addr_i(addr_i), .rd_wide_i(word_mode_i), .rd_data_o(arr_rd)
  );

  assign rdata_o = sel ? arr_rd : 16'h0000;
  assign ready_o = !(q_valid || e_act || p_act);
  assign gsr_o   = {3'b000, ovf, p_act, e_act, e_act || p_act, q_valid};

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_bsr
    assign bsr_o[3*b +: 3] = {(e_act && e_blk == BLK_W'(b)) || (p_act && p_blk == BLK_W'(b)),
                              lock_err[b], locked[b]};
  end

  // R8
  engines_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_act && p_act) |-> (e_blk != p_blk));

  // R7
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid && q_valid) |=> ovf);

  // R6
  queue_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid && !e_start && !p_start) |=> q_valid);

  // R10
  lock_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((locked & $past(locked)) == $past(locked)));
endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int NB = 16, BB = 4, PC = 3, EC = 8, DEPTH = NB * BB;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce0_ni = 1'b0, ce1_ni = 1'b0, wr_i = 1'b0, word_mode_i = 1'b0, wp_ni = 1'b1;
  logic [5:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic ready_o;
  logic [7:0] gsr_o;
  logic [3*NB-1:0] bsr_o;

  int vecs = 0, errs = 0;
  logic [7:0] exp_mem [DEPTH];

  always #2 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk_i(clk), .rst_ni, .ce0_ni, .ce1_ni, .wr_i, .word_mode_i, .addr_i, .wdata_i,
    .wp_ni, .rdata_o, .ready_o, .gsr_o, .bsr_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic prog_byte(input logic [5:0] a, input logic [7:0] d);
    bus_write(a, 16'h0040);
    bus_write(a, {8'h00, d});
  endtask

  task automatic erase_blk(input int b);
    bus_write(6'(b * BB), 16'h0020);
    bus_write(6'(b * BB), 16'h00D0);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!ready_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_all(input string tag);
    word_mode_i = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      addr_i = 6'(a);
      #0.1;
      chk(tag, rdata_o, {8'h00, exp_mem[a]});
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    vecs++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 ready", ready_o, 1);
    chk("R12 gsr", gsr_o, 0);
    chk("R12 bsr", bsr_o, 0);
    check_all("R12 erased array");

    // R3 / R5 byte program sweep
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] d = 8'(a * 37 + 11);
      prog_byte(6'(a), d);
      wait_idle(n);
      if (a < 4) chk("R5 program busy cycles", n, PC + 1);
      exp_mem[a] &= d;
    end
    check_all("R3 first program");
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] d = 8'(a * 91 + 8'h5A);
      prog_byte(6'(a), d);
      wait_idle(n);
      exp_mem[a] &= d;
    end
    check_all("R3 and-only program");

    // R11 word mode
    word_mode_i = 1'b1;
    for (int w = 0; w < DEPTH / 2; w++) begin
      addr_i = {5'(w), 1'b1};
      #0.1;
      chk("R11 word read", rdata_o, {exp_mem[2*w+1], exp_mem[2*w]});
    end
    @(negedge clk);
    bus_write(6'd13, 16'h0040);
    bus_write(6'd13, 16'h0F3C);
    wait_idle(n);
    exp_mem[12] &= 8'h3C;
    exp_mem[13] &= 8'h0F;
    check_all("R11 word program");

    // R4 erase sweep
    for (int b = 0; b < NB; b++) begin
      erase_blk(b);
      wait_idle(n);
      if (b == 0) chk("R5 erase busy cycles", n, EC + 1);
      for (int k = 0; k < BB; k++) exp_mem[b*BB+k] = 8'hFF;
      check_all("R4 erase one block");
      prog_byte(6'(b * BB + (b % BB)), 8'(b * 17));
      wait_idle(n);
      exp_mem[b*BB+(b%BB)] &= 8'(b * 17);
    end
    check_all("R4 refill");

    // R2 abandoned and stray codes
    bus_write(6'd12, 16'h0020);
    bus_write(6'd12, 16'h0033);
    chk("R2 bad confirm ready", ready_o, 1);
    bus_write(6'd12, 16'h00D0);
    chk("R2 lone confirm ready", ready_o, 1);
    check_all("R2 array unchanged");

    // R1 chip enables
    ce1_ni = 1'b1;
    erase_blk(2);
    chk("R1 ce1 high ready", ready_o, 1);
    addr_i = 6'd8; #0.1;
    chk("R1 rdata deselected", rdata_o, 0);
    @(negedge clk);
    ce1_ni = 1'b0; ce0_ni = 1'b1;
    bus_write(6'd8, 16'h0020);
    ce0_ni = 1'b0;
    bus_write(6'd8, 16'h00D0);
    chk("R1 setup ignored when deselected", ready_o, 1);
    check_all("R1 array unchanged");

    // R6 / R7 queue and overflow
    erase_blk(2);
    erase_blk(5);
    chk("R6 queue full bit", gsr_o[0], 1);
    chk("R6 erase active", gsr_o[2], 1);
    prog_byte(6'd28, 8'h00);
    chk("R7 overflow set", gsr_o[4], 1);
    wait_idle(n);
    for (int k = 0; k < BB; k++) begin
      exp_mem[2*BB+k] = 8'hFF;
      exp_mem[5*BB+k] = 8'hFF;
    end
    check_all("R6 queued erase done, R7 dropped program");
    chk("R7 overflow sticky", gsr_o[4], 1);
    bus_write(6'd0, 16'h0050);
    chk("R7 clear status", gsr_o, 0);

    // R8 concurrent program during erase
    erase_blk(4);
    prog_byte(6'd37, 8'h5A);
    @(negedge clk);
    chk("R8 both engines", gsr_o[3:2], 2'b11);
    chk("R8 erasing block busy", bsr_o[3*4+2], 1);
    repeat (3) @(negedge clk);
    exp_mem[37] &= 8'h5A;
    chk("R8 program done first", gsr_o[3:2], 2'b01);
    addr_i = 6'd37; #0.1;
    chk("R8 programmed data", rdata_o, {8'h00, exp_mem[37]});
    @(negedge clk);
    wait_idle(n);
    for (int k = 0; k < BB; k++) exp_mem[4*BB+k] = 8'hFF;
    check_all("R8 final array");

    // R9 same-block program waits
    erase_blk(6);
    prog_byte(6'd26, 8'h3C);
    @(negedge clk);
    chk("R9 program held", gsr_o[3:0], 4'b0111);
    wait_idle(n);
    for (int k = 0; k < BB; k++) exp_mem[6*BB+k] = 8'hFF;
    exp_mem[26] = 8'h3C;
    check_all("R9 erase then program");

    // R10 locking
    wp_ni = 1'b0;
    bus_write(6'd40, 16'h0060);
    bus_write(6'd40, 16'h0001);
    chk("R10 lock set", bsr_o[30 +: 3], 3'b001);
    prog_byte(6'd41, 8'h00);
    chk("R10 program refused", ready_o, 1);
    chk("R10 lock error", bsr_o[30 +: 3], 3'b011);
    erase_blk(10);
    chk("R10 erase refused", ready_o, 1);
    check_all("R10 locked block unchanged");
    prog_byte(6'd44, 8'h0F);
    wait_idle(n);
    exp_mem[44] &= 8'h0F;
    check_all("R10 unlocked block under protect");
    wp_ni = 1'b1;
    prog_byte(6'd41, 8'h81);
    wait_idle(n);
    exp_mem[41] &= 8'h81;
    check_all("R10 protect released");
    bus_write(6'd0, 16'h0050);
    chk("R10 error cleared, lock kept", bsr_o[30 +: 3], 3'b001);
    chk("R12 idle status", {ready_o, gsr_o}, 9'h100);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule